// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block sits between a set of peripheral interrupt lines and a simple CPU sequencer. Each line passes through its own synchronizer and a sense detector that can be programmed per source for a low level, a high level, a falling edge or a rising edge. A detected event latches a per-source pending flag. The pending flags are masked by per-source enables and by one global enable. The lowest-numbered surviving source is then presented to the sequencer as a single request.

The sequencer accepts the request by completing an instruction while the request is raised. On that cycle the block clears the winner's pending flag and the global enable. One cycle later it emits a one-cycle acknowledge strobe together with the winner's index. The global enable is driven by set, clear and return strobes. After a set or a return, one more instruction must complete before any request is shown, so software always runs at least one instruction before the next handler is entered.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Each source has a 2-bit sense field in `irq_mode_i` at bits [2i+1:2i], coded 00 = low level, 01 = high level, 10 = falling edge, 11 = rising edge. The all-zero value, active low, is the default for wire-ORed lines. A transition that does not match the chosen edge sets nothing.
- R2: A single matching edge sets the pending flag exactly once. The flag stays set after the line returns to idle and is cleared only when that source is acknowledged.
- R3: `irq_req_o` is high only when some source has its pending flag, its bit in `src_en_i` and the global enable all set. A pending but disabled source stays latched.
- R4: The global enable is cleared by reset and by `gie_clr_i`. A clear strobe drops `irq_req_o` in the same cycle it is applied.
- R5: On acceptance, the global enable and the accepted source's pending flag are cleared. Other pending flags are kept.
- R6: A request is accepted only on a cycle where `irq_req_o` and `instr_done_i` are both high. `ack_o` is high for exactly the following cycle, with `ack_id_o` giving the accepted index.
- R7: After `gie_set_i` or `reti_i`, which both set the global enable, `irq_req_o` stays low until `instr_done_i` has been high in a later cycle.
- R8: When several enabled sources are pending, the lowest index is acknowledged.
- R9: A new matching edge whose pending set lands on the same edge that clears that source's flag leaves the flag set.
- R10: A level-sensitive source that is still active after its acknowledge becomes pending again.
- R11: After reset, `irq_req_o` and `ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_line_i | input | N_SRC | Raw interrupt lines, asynchronous |
| irq_mode_i | input | 2*N_SRC | Per-source sense selection |
| src_en_i | input | N_SRC | Per-source enables |
| gie_set_i | input | 1 | Set global enable |
| gie_clr_i | input | 1 | Clear global enable, immediate |
| reti_i | input | 1 | Return-from-interrupt strobe, sets global enable |
| instr_done_i | input | 1 | Current instruction has completed |
| irq_req_o | output | 1 | Request to the sequencer |
| ack_o | output | 1 | One-cycle acknowledge strobe |
| ack_id_o | output | $clog2(N_SRC) | Index of the acknowledged source |

## Verification
Two things can fall in the same cycle: the clear of a source's pending flag on acceptance, and a fresh edge on that same line setting the flag again. The bench raises a rising edge on source 0 at a time chosen by counting the synchronizer stages, so that its detection lands on the edge where the instruction-complete strobe accepts source 0. It then re-arms the global enable and expects source 0 to be requested and acknowledged a second time, and then no third time. The set and clear strobes are also driven together while a request is live, and the clear must win.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // per-source sense selection; zero is the idle-high, active-low default
   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_HIGH = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

endpackage

// File: rtl/irqc_cond.sv
// Per-source conditioning: synchronizer, sense detect, pending flag
module irqc_cond
   import irqc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   line_i,
   input  sense_e mode_i,
   input  logic   clr_i,
   output logic   pend_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [SYNC_STAGES:0]   warm_q;
   logic                   prev_q;
   logic                   pend_q;
   logic                   cur;
   logic                   hit;

   assign cur = sync_q[SYNC_STAGES-1];

   always_comb begin
      unique case (mode_i)
         SENSE_LOW:  hit = ~cur;
         SENSE_HIGH: hit = cur;
         SENSE_FALL: hit = prev_q & ~cur;
         SENSE_RISE: hit = ~prev_q & cur;
         default:    hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
         warm_q <= '0;
         pend_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
         prev_q <= cur;
         warm_q <= {warm_q[SYNC_STAGES-1:0], 1'b1};
         // set wins over clear so an event on the clearing edge is kept
         pend_q <= (pend_q & ~clr_i) | (hit & warm_q[SYNC_STAGES]);
      end
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/irqc_prio.sv
// Fixed priority: lowest index wins
module irqc_prio #(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned ID_W  = 3
) (
   input  logic [N_SRC-1:0] req_i,
   output logic             any_o,
   output logic [ID_W-1:0]  id_o
);

   always_comb begin
      id_o = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (req_i[i]) id_o = ID_W'(i);
      end
   end

   assign any_o = |req_i;

endmodule

// File: rtl/irqc_gate.sv
// Global enable and one-instruction hold after set/return
module irqc_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic reti_i,
   input  logic done_i,
   input  logic take_i,
   output logic open_o
);

   logic gie_q;
   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q  <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         if (clr_i || take_i)         gie_q <= 1'b0;
         else if (set_i || reti_i)    gie_q <= 1'b1;

         if ((set_i || reti_i) && !take_i) hold_q <= 1'b1;
         else if (done_i)                  hold_q <= 1'b0;
      end
   end

   // clear acts in its own cycle
   assign open_o = gie_q & ~hold_q & ~clr_i;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irqc_pkg::*;
#(
   parameter  int unsigned N_SRC       = 8,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned ID_W        = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_SRC-1:0]   irq_line_i,
   input  logic [2*N_SRC-1:0] irq_mode_i,
   input  logic [N_SRC-1:0]   src_en_i,
   input  logic               gie_set_i,
   input  logic               gie_clr_i,
   input  logic               reti_i,
   input  logic               instr_done_i,
   output logic               irq_req_o,
   output logic               ack_o,
   output logic [ID_W-1:0]    ack_id_o
);

   if (N_SRC < 2) begin : g_bad_nsrc
      $error("irq_prio_ctrl: N_SRC must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_prio_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] live;
   logic [N_SRC-1:0] clr_vec;
   logic             any_live;
   logic [ID_W-1:0]  win_id;
   logic             gate_open;
   logic             take;
   logic             ack_q;
   logic [ID_W-1:0]  ack_id_q;

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      irqc_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (irq_line_i[g]),
         .mode_i (sense_e'(irq_mode_i[2*g +: 2])),
         .clr_i  (clr_vec[g]),
         .pend_o (pend[g])
      );
      assign clr_vec[g] = take && (win_id == ID_W'(g));
   end

   assign live = pend & src_en_i;

   irqc_prio #(.N_SRC(N_SRC), .ID_W(ID_W)) u_prio (
      .req_i (live),
      .any_o (any_live),
      .id_o  (win_id)
   );

   irqc_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (gie_set_i),
      .clr_i  (gie_clr_i),
      .reti_i (reti_i),
      .done_i (instr_done_i),
      .take_i (take),
      .open_o (gate_open)
   );

   assign irq_req_o = any_live & gate_open;
   assign take      = irq_req_o & instr_done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q    <= 1'b0;
         ack_id_q <= '0;
      end else begin
         ack_q <= take;
         if (take) ack_id_q <= win_id;
      end
   end

   assign ack_o    = ack_q;
   assign ack_id_o = ack_id_q;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter  int unsigned N_SRC = 8,
   localparam int unsigned ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] src_en_i,
   input logic             gie_set_i,
   input logic             gie_clr_i,
   input logic             reti_i,
   input logic             instr_done_i,
   input logic             irq_req_o,
   input logic             ack_o,
   input logic [ID_W-1:0]  ack_id_o
);

   logic [N_SRC-1:0] en_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_d <= '0;
      else        en_d <= src_en_i;
   end

   // R6
   ack_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> $past(irq_req_o && instr_done_i));

   // R6
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);

   // R5
   ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> !irq_req_o);

   // R4
   clr_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gie_clr_i |-> !irq_req_o);

   // R7
   set_defers_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gie_set_i || reti_i) |=> !irq_req_o);

   // R3
   ack_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> en_d[ack_id_o]);

endmodule

bind irq_prio_ctrl irqc_chk #(.N_SRC(N_SRC)) u_irqc_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .src_en_i     (src_en_i),
   .gie_set_i    (gie_set_i),
   .gie_clr_i    (gie_clr_i),
   .reti_i       (reti_i),
   .instr_done_i (instr_done_i),
   .irq_req_o    (irq_req_o),
   .ack_o        (ack_o),
   .ack_id_o     (ack_id_o)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   line = '0;
   logic [15:0]  mode = {8{2'b01}};
   logic [7:0]   en = '0;
   logic         set = 1'b0, clr = 1'b0, reti = 1'b0, done = 1'b0;
   logic         req, ack;
   logic [2:0]   ack_id;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   irq_prio_ctrl #(.N_SRC(N)) i_irq_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_line_i(line), .irq_mode_i(mode),
      .src_en_i(en), .gie_set_i(set), .gie_clr_i(clr), .reti_i(reti),
      .instr_done_i(done), .irq_req_o(req), .ack_o(ack), .ack_id_o(ack_id)
   );

   typedef struct packed {
      logic [7:0] lines;
      logic [7:0] ens;
      logic       exp_req;
      logic [2:0] exp_id;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{8'b0000_0110, 8'hFF, 1'b1, 3'd1},
      '{8'b1000_0000, 8'hFF, 1'b1, 3'd7},
      '{8'b1111_1111, 8'hFE, 1'b1, 3'd1},
      '{8'b0010_0100, 8'h04, 1'b1, 3'd2},
      '{8'b0001_0000, 8'hEF, 1'b0, 3'd0},
      '{8'b1010_1000, 8'hFF, 1'b1, 3'd3}
   };

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_set();
      set = 1'b1; tick(); set = 1'b0;
   endtask

   task automatic pulse_done();
      done = 1'b1; tick(); done = 1'b0;
   endtask

   task automatic arm();
      pulse_set();
      pulse_done();
   endtask

   task automatic take_chk(input int exp_id, input string tag);
      chk(req === 1'b1, {tag, " req"}, int'(req), 1);
      pulse_done();
      chk(ack === 1'b1 && int'(ack_id) == exp_id, {tag, " ack id"},
          ack ? int'(ack_id) : -1, exp_id);
   endtask

   task automatic flush();
      line = '0; en = 8'hFF; mode = {8{2'b01}};
      repeat (4) tick();
      for (int k = 0; k < 10; k++) begin
         arm();
         if (req) pulse_done();
      end
      tick();
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R11 reset state
      chk(req === 1'b0, "R11 req after reset", int'(req), 0);
      chk(ack === 1'b0, "R11 ack after reset", int'(ack), 0);

      // table: priority and masking, all sources high-level sensitive
      for (int v = 0; v < 6; v++) begin
         flush();
         line = VECS[v].lines; en = VECS[v].ens;
         repeat (4) tick();
         pulse_set();
         chk(req === 1'b0, "R7 held after set", int'(req), 0);
         pulse_done();
         chk(req === VECS[v].exp_req, "R3/R8 request", int'(req), int'(VECS[v].exp_req));
         if (VECS[v].exp_req) take_chk(int'(VECS[v].exp_id), "R8 winner");
         line = '0;
      end

      // R1 low level (code 00) and R10 re-pend while still active
      flush();
      mode[7:6] = 2'b00;
      repeat (4) tick();
      arm();
      take_chk(3, "R1 low level");
      tick();
      chk(ack === 1'b0, "R6 ack one cycle", int'(ack), 0);
      arm();
      take_chk(3, "R10 level re-pend");
      mode[7:6] = 2'b01;

      // R1 falling edge (code 10): rise ignored, fall taken once
      flush();
      mode[11:10] = 2'b10;
      line[5] = 1'b1;
      repeat (4) tick();
      arm();
      chk(req === 1'b0, "R1 rise ignored in fall mode", int'(req), 0);
      line[5] = 1'b0;
      repeat (4) tick();
      take_chk(5, "R1 falling edge");
      arm();
      chk(req === 1'b0, "R2 single fall sets once", int'(req), 0);

      // R1 rising edge (code 11) short pulse, R2 pending persists
      flush();
      mode[13:12] = 2'b11;
      line[6] = 1'b1;
      repeat (3) tick();
      line[6] = 1'b0;
      repeat (4) tick();
      arm();
      take_chk(6, "R2 pending after pulse");
      arm();
      chk(req === 1'b0, "R2 no second pending", int'(req), 0);

      // R3 enable mask, R6 no ack without done, R4 immediate clear
      flush();
      en = 8'hFB; line[2] = 1'b1;
      repeat (4) tick();
      line[2] = 1'b0;
      arm();
      chk(req === 1'b0, "R3 disabled source masked", int'(req), 0);
      en[2] = 1'b1;
      #1;
      chk(req === 1'b1, "R3 enable exposes pending", int'(req), 1);
      repeat (3) tick();
      chk(ack === 1'b0, "R6 no ack without done", int'(ack), 0);
      set = 1'b1; clr = 1'b1;
      #1;
      chk(req === 1'b0, "R4 clear same cycle", int'(req), 0);
      tick(); set = 1'b0; clr = 1'b0;
      #1;
      chk(req === 1'b0, "R4 clear wins over set", int'(req), 0);
      arm();
      take_chk(2, "R4 pending kept across clear");

      // R5 global enable dropped on ack, R7 return needs one instruction
      flush();
      line[1] = 1'b1; line[4] = 1'b1;
      repeat (4) tick();
      line = '0;
      repeat (4) tick();
      arm();
      take_chk(1, "R5 first of two");
      chk(req === 1'b0, "R5 gie cleared by ack", int'(req), 0);
      pulse_done();
      chk(req === 1'b0, "R5 no nesting without set", int'(req), 0);
      reti = 1'b1; tick(); reti = 1'b0;
      chk(req === 1'b0, "R7 held after return", int'(req), 0);
      pulse_done();
      take_chk(4, "R7 other pending after return");

      // R9 edge landing on the clearing edge is kept
      flush();
      mode[1:0] = 2'b11;
      line[0] = 1'b1;
      repeat (4) tick();
      line[0] = 1'b0;
      repeat (4) tick();
      arm();
      chk(req === 1'b1, "R9 setup req", int'(req), 1);
      line[0] = 1'b1;
      tick(); tick();
      pulse_done();
      chk(ack === 1'b1 && ack_id == 3'd0, "R9 first ack", int'(ack_id), 0);
      arm();
      take_chk(0, "R9 collided edge kept");
      arm();
      chk(req === 1'b0, "R9 no third request", int'(req), 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule